// File: doc/BRIEF.md
# Debug Trigger Firing-Enable Gate

This block sits between the comparators of a set of hardware debug triggers and the logic that raises the resulting exception or debug entry. For each trigger it takes the comparator's raw hit, the result of the trigger's privilege-mode check and the result of its extra-context check, along with the trigger's action code. It produces a qualified signal that says the trigger may count or match, and a fire signal that says it fires now. The same qualification serves address/data match triggers, trap and interrupt triggers, and instruction-count triggers. For an instruction-count trigger, the qualified signal gates the decrement and the fire signal gates the firing.

Triggers whose action is the breakpoint exception (code 0) can re-enter the handler that services them. The gate holds such triggers off in that situation. A build with supervisor mode (`HAS_SMODE = 1`) decides this from the global interrupt-enable bits and the breakpoint-delegation bits. A build without supervisor mode holds a small trigger-control register instead. That register keeps a machine-trigger-enable bit and a saved copy of it. Trap entry saves the bit into the copy, trap return restores it, and software can also write it.

Top module: `trg_fire_gate`

## Requirements
- R1: After reset, `tctl_rdata_o` reads all zeros.
- R2: A trigger whose action code is not 0 is qualified exactly when its mode check and its context check both pass. Every trigger's fire output equals its qualified output ANDed with its raw hit.
- R3: If either the mode check or the context check of a trigger fails, that trigger is neither qualified nor fired, whatever its action or the privilege state.
- R4: With supervisor mode, an action-0 trigger is blocked in M privilege (`priv_i` = 2'b11) while the machine interrupt-enable bit is 0.
- R5: With supervisor mode, an action-0 trigger is blocked in S privilege (`priv_i` = 2'b01) with `virt_i` = 0 when machine breakpoint delegation is 1 and the supervisor interrupt-enable bit is 0.
- R6: With supervisor mode, an action-0 trigger is blocked in S privilege with `virt_i` = 1 when both delegation bits are 1 and the virtual-supervisor interrupt-enable bit is 0. Action-0 triggers in U privilege (2'b00) are never blocked.
- R7: With supervisor mode there is no trigger-control register. `tctl_rdata_o` stays zero through writes, trap entries and trap returns.
- R8: Without supervisor mode, an action-0 trigger is blocked in M privilege exactly when the enable bit (bit 3) is 0. In every other privilege it is not blocked.
- R9: On a clock edge with `trap_enter_i` high, the saved bit (bit 7) takes the old enable bit and the enable bit clears.
- R10: On a clock edge with `trap_return_i` high and no trap entry, the enable bit and the saved bit both take the old saved bit.
- R11: Trap entry outranks trap return, and both outrank a software write in the same cycle.
- R12: A software write stores only bit 3 and bit 7 of `tctl_wdata_i`. All other bits read as zero.
- R13: The qualified and fire outputs respond to the current inputs in the same cycle, with no register between inputs and outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| priv_i | input | 2 | Current privilege: 00 U, 01 S, 11 M |
| virt_i | input | 1 | Virtualization active |
| mstatus_mie_i | input | 1 | Machine global interrupt enable |
| sstatus_sie_i | input | 1 | Supervisor global interrupt enable |
| vsstatus_sie_i | input | 1 | Virtual-supervisor global interrupt enable |
| medeleg_bp_i | input | 1 | Machine breakpoint-exception delegation bit |
| hedeleg_bp_i | input | 1 | Hypervisor breakpoint-exception delegation bit |
| trap_enter_i | input | 1 | Trap taken into M privilege this cycle |
| trap_return_i | input | 1 | Machine trap return this cycle |
| tctl_we_i | input | 1 | Software write to trigger-control register |
| tctl_wdata_i | input | XLEN | Write data |
| tctl_rdata_o | output | XLEN | Trigger-control register read value |
| trig_action_i | input | NTRIG*ACTW | Action code per trigger, trigger 0 in the low bits |
| trig_mode_ok_i | input | NTRIG | Privilege-mode check passed, per trigger |
| trig_ctx_ok_i | input | NTRIG | Extra-context check passed, per trigger |
| trig_hit_i | input | NTRIG | Raw comparator hit, per trigger |
| trig_qual_o | output | NTRIG | Trigger qualified to count or match |
| trig_fire_o | output | NTRIG | Trigger fires |

## Verification
Three register updates can fall in the same cycle: trap entry, trap return and a software write to the trigger-control register. The bench first loads known enable and saved bits with a software write. It then asserts two or three of the update sources on the same edge, and compares the read value with the result of the higher-priority update applied alone to the preloaded bits. A second overlap is also checked: the combinational gate is swept over every privilege, status and delegation pattern for both enable-bit values. The bench writes the enable bit and then confirms that the next sweep sees the new value, so a register update and gate evaluation meet in one run.

// File: rtl/trg_gate_pkg.sv
// Package: shared encodings for the trigger firing-enable gate.
// Assumes privilege codes follow the usual two-bit U/S/M numbering.
package trg_gate_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    // Bit positions of the trigger-control register fields.
    localparam int unsigned TCTL_EN_POS   = 3;
    localparam int unsigned TCTL_SAVE_POS = 7;

    // Action code that raises a breakpoint exception.
    localparam int unsigned ACT_BKPT = 0;

endpackage

// File: rtl/trg_ctl_reg.sv
// Module: trg_ctl_reg
// Holds the machine-trigger-enable bit and its saved copy when PRESENT = 1.
// Trap entry saves and clears, trap return restores, software write loads.
// Priority: entry > return > write. When PRESENT = 0 it reads as zero.
// Assumes XLEN is wide enough to hold bit TCTL_SAVE_POS.
module trg_ctl_reg
    import trg_gate_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter bit          PRESENT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter_i,
    input  logic            return_i,
    input  logic            we_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic            en_o,
    output logic [XLEN-1:0] rdata_o
);

    generate
        if (PRESENT) begin : g_reg
            logic en_q;
            logic save_q;
            logic unused_wdata;

            // Collapse the write-data bits that have no storage.
            assign unused_wdata = ^(wdata_i & ~((XLEN'(1) << TCTL_EN_POS) |
                                                (XLEN'(1) << TCTL_SAVE_POS)));

            // Update the two bits on trap entry, trap return or software write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q   <= 1'b0;
                    save_q <= 1'b0;
                end else if (enter_i) begin
                    save_q <= en_q;
                    en_q   <= 1'b0;
                end else if (return_i) begin
                    en_q   <= save_q;
                    save_q <= save_q;
                end else if (we_i) begin
                    en_q   <= wdata_i[TCTL_EN_POS];
                    save_q <= wdata_i[TCTL_SAVE_POS];
                end
            end

            // Assemble the read value with all other bits at zero.
            always_comb begin
                rdata_o                = '0;
                rdata_o[TCTL_EN_POS]   = en_q;
                rdata_o[TCTL_SAVE_POS] = save_q;
            end

            assign en_o = en_q;

            // R9
            trap_enter_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
                enter_i |=> (save_q == $past(en_q)) && !en_q);

            // R10
            trap_return_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (return_i && !enter_i) |=> (en_q == $past(save_q)) && (save_q == $past(save_q)));

            // R11
            write_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (we_i && !enter_i && !return_i) |=>
                    (en_q == $past(wdata_i[TCTL_EN_POS])) && (save_q == $past(wdata_i[TCTL_SAVE_POS])));

            // R12
            rdata_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(rdata_o) == ($countones(en_q) + $countones(save_q)));
        end else begin : g_none
            logic unused_inputs;

            // No storage: every input is intentionally ignored.
            assign unused_inputs = ^{clk, rst_n, enter_i, return_i, we_i, wdata_i};
            assign en_o    = 1'b0;
            assign rdata_o = '0;
        end
    endgenerate

endmodule

// File: rtl/trg_a0_permit.sv
// Module: trg_a0_permit
// Decides whether breakpoint-action triggers may match in the current state.
// HAS_SMODE = 1 uses interrupt-enable and delegation bits; HAS_SMODE = 0 uses
// the machine-trigger-enable bit. Assumes the privilege code is stable per cycle.
module trg_a0_permit
    import trg_gate_pkg::*;
#(
    parameter bit HAS_SMODE = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] priv_i,
    input  logic       virt_i,
    input  logic       mie_i,
    input  logic       sie_i,
    input  logic       vsie_i,
    input  logic       medeleg_i,
    input  logic       hedeleg_i,
    input  logic       mte_i,
    output logic       permit_o
);

    logic in_m;
    logic in_s;

    assign in_m = (priv_i == PRIV_M);
    assign in_s = (priv_i == PRIV_S);

    generate
        if (HAS_SMODE) begin : g_smode
            logic blk_m;
            logic blk_hs;
            logic blk_vs;
            logic unused_mte;

            assign unused_mte = mte_i;

            // Block in each privilege when its own handler cannot be re-entered safely.
            always_comb begin
                blk_m  = in_m && !mie_i;
                blk_hs = in_s && !virt_i && medeleg_i && !sie_i;
                blk_vs = in_s && virt_i && medeleg_i && hedeleg_i && !vsie_i;
            end

            assign permit_o = !(blk_m || blk_hs || blk_vs);

            // R4
            m_no_mie_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_m && !mie_i) |-> !permit_o);

            // R5
            hs_deleg_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_s && !virt_i && medeleg_i && !sie_i) |-> !permit_o);

            // R6
            vs_deleg_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_s && virt_i && medeleg_i && hedeleg_i && !vsie_i) |-> !permit_o);

            // R6
            user_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (priv_i == PRIV_U) |-> permit_o);
        end else begin : g_mte
            logic unused_status;

            assign unused_status = ^{virt_i, mie_i, sie_i, vsie_i, medeleg_i, hedeleg_i, in_s};

            // Only M privilege consults the enable bit.
            assign permit_o = !in_m || mte_i;

            // R8
            m_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_m |-> (permit_o == mte_i));
        end
    endgenerate

endmodule

// File: rtl/trg_qualify.sv
// Module: trg_qualify
// Combines one trigger's mode check, context check and action code with the
// shared breakpoint permit into a qualified and a fire signal.
// Assumes the comparator hit is valid in the same cycle as the checks.
module trg_qualify
    import trg_gate_pkg::*;
#(
    parameter int unsigned ACTW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ACTW-1:0] action_i,
    input  logic            mode_ok_i,
    input  logic            ctx_ok_i,
    input  logic            hit_i,
    input  logic            permit_i,
    output logic            qual_o,
    output logic            fire_o
);

    logic is_bkpt;

    // Qualify: both checks first, then suppression for breakpoint actions.
    always_comb begin
        is_bkpt = (action_i == ACTW'(ACT_BKPT));
        qual_o  = mode_ok_i && ctx_ok_i && (!is_bkpt || permit_i);
        fire_o  = qual_o && hit_i;
    end

    // R3
    checks_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_ok_i && ctx_ok_i) |-> !qual_o && !fire_o);

    // R2
    fire_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> hit_i && qual_o);

    // R2
    other_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (action_i != ACTW'(ACT_BKPT)) |-> (qual_o == (mode_ok_i && ctx_ok_i)));

endmodule

// File: rtl/trg_fire_gate.sv
// Module: trg_fire_gate (top)
// Qualifies NTRIG debug triggers against the privilege state so breakpoint
// triggers cannot re-enter their own handler. Holds the trigger-control
// register only when HAS_SMODE = 0. Outputs are combinational.
module trg_fire_gate
    import trg_gate_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned NTRIG     = 2,
    parameter int unsigned ACTW      = 4,
    parameter bit          HAS_SMODE = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            priv_i,
    input  logic                  virt_i,
    input  logic                  mstatus_mie_i,
    input  logic                  sstatus_sie_i,
    input  logic                  vsstatus_sie_i,
    input  logic                  medeleg_bp_i,
    input  logic                  hedeleg_bp_i,
    input  logic                  trap_enter_i,
    input  logic                  trap_return_i,
    input  logic                  tctl_we_i,
    input  logic [XLEN-1:0]       tctl_wdata_i,
    output logic [XLEN-1:0]       tctl_rdata_o,
    input  logic [NTRIG*ACTW-1:0] trig_action_i,
    input  logic [NTRIG-1:0]      trig_mode_ok_i,
    input  logic [NTRIG-1:0]      trig_ctx_ok_i,
    input  logic [NTRIG-1:0]      trig_hit_i,
    output logic [NTRIG-1:0]      trig_qual_o,
    output logic [NTRIG-1:0]      trig_fire_o
);

    localparam bit TCTL_PRESENT = !HAS_SMODE;

    logic mte;
    logic permit;

    trg_ctl_reg #(
        .XLEN    (XLEN),
        .PRESENT (TCTL_PRESENT)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter_i  (trap_enter_i),
        .return_i (trap_return_i),
        .we_i     (tctl_we_i),
        .wdata_i  (tctl_wdata_i),
        .en_o     (mte),
        .rdata_o  (tctl_rdata_o)
    );

    trg_a0_permit #(
        .HAS_SMODE (HAS_SMODE)
    ) u_permit (
        .clk       (clk),
        .rst_n     (rst_n),
        .priv_i    (priv_i),
        .virt_i    (virt_i),
        .mie_i     (mstatus_mie_i),
        .sie_i     (sstatus_sie_i),
        .vsie_i    (vsstatus_sie_i),
        .medeleg_i (medeleg_bp_i),
        .hedeleg_i (hedeleg_bp_i),
        .mte_i     (mte),
        .permit_o  (permit)
    );

    generate
        for (genvar t = 0; t < NTRIG; t++) begin : g_trig
            trg_qualify #(
                .ACTW (ACTW)
            ) u_q (
                .clk       (clk),
                .rst_n     (rst_n),
                .action_i  (trig_action_i[t*ACTW +: ACTW]),
                .mode_ok_i (trig_mode_ok_i[t]),
                .ctx_ok_i  (trig_ctx_ok_i[t]),
                .hit_i     (trig_hit_i[t]),
                .permit_i  (permit),
                .qual_o    (trig_qual_o[t]),
                .fire_o    (trig_fire_o[t])
            );
        end
    endgenerate

    // R7
    no_reg_with_smode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        HAS_SMODE |-> (tctl_rdata_o == '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (tctl_rdata_o == '0));

endmodule

// File: tb/trg_fire_gate_bench.sv
// Bench: sweeps both build variants over all privilege/status/delegation
// patterns and drives the trigger-control register through its update cases.
module trg_fire_gate_bench;

    localparam int XLEN  = 32;
    localparam int NTRIG = 2;
    localparam int ACTW  = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic [1:0] priv;
    logic virt, mie, sie, vsie, md, hd;
    logic t_enter, t_ret, we;
    logic [XLEN-1:0] wdata;
    logic [NTRIG*ACTW-1:0] act;
    logic [NTRIG-1:0] mode_ok, ctx_ok, hit;
    logic [XLEN-1:0] rd_n, rd_s;
    logic [NTRIG-1:0] qual_n, fire_n, qual_s, fire_s;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    trg_fire_gate #(.XLEN(XLEN), .NTRIG(NTRIG), .ACTW(ACTW), .HAS_SMODE(1'b0)) u_trg_fire_gate (
        .clk(clk), .rst_n(rst_n), .priv_i(priv), .virt_i(virt),
        .mstatus_mie_i(mie), .sstatus_sie_i(sie), .vsstatus_sie_i(vsie),
        .medeleg_bp_i(md), .hedeleg_bp_i(hd),
        .trap_enter_i(t_enter), .trap_return_i(t_ret),
        .tctl_we_i(we), .tctl_wdata_i(wdata), .tctl_rdata_o(rd_n),
        .trig_action_i(act), .trig_mode_ok_i(mode_ok), .trig_ctx_ok_i(ctx_ok),
        .trig_hit_i(hit), .trig_qual_o(qual_n), .trig_fire_o(fire_n));

    trg_fire_gate #(.XLEN(XLEN), .NTRIG(NTRIG), .ACTW(ACTW), .HAS_SMODE(1'b1)) u_trg_fire_gate_smode (
        .clk(clk), .rst_n(rst_n), .priv_i(priv), .virt_i(virt),
        .mstatus_mie_i(mie), .sstatus_sie_i(sie), .vsstatus_sie_i(vsie),
        .medeleg_bp_i(md), .hedeleg_bp_i(hd),
        .trap_enter_i(t_enter), .trap_return_i(t_ret),
        .tctl_we_i(we), .tctl_wdata_i(wdata), .tctl_rdata_o(rd_s),
        .trig_action_i(act), .trig_mode_ok_i(mode_ok), .trig_ctx_ok_i(ctx_ok),
        .trig_hit_i(hit), .trig_qual_o(qual_s), .trig_fire_o(fire_s));

    task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
        n_cmp++;
        if (actual !== expected) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    // Apply one register operation for one edge, then check both read values.
    task automatic reg_op(input logic w, input logic [XLEN-1:0] d, input logic en, input logic rt,
                          input string req, input logic [31:0] exp_n);
        @(negedge clk);
        we = w; wdata = d; t_enter = en; t_ret = rt;
        @(negedge clk);
        we = 1'b0; wdata = '0; t_enter = 1'b0; t_ret = 1'b0;
        chk(req, rd_n, exp_n);
        chk("R7", rd_s, 32'h0);
    endtask

    function automatic logic permit_s(logic [1:0] p, logic v, logic ie_m, logic ie_s,
                                      logic ie_vs, logic dm, logic dh);
        if (p == 2'b11 && !ie_m) return 1'b0;
        if (p == 2'b01 && !v && dm && !ie_s) return 1'b0;
        if (p == 2'b01 && v && dm && dh && !ie_vs) return 1'b0;
        return 1'b1;
    endfunction

    initial begin
        rst_n = 1'b0; priv = 2'b00; virt = 0; mie = 0; sie = 0; vsie = 0; md = 0; hd = 0;
        t_enter = 0; t_ret = 0; we = 0; wdata = '0; act = '0; mode_ok = '0; ctx_ok = '0; hit = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", rd_n, 32'h0);
        chk("R7", rd_s, 32'h0);

        // Register update cases (no-S build): bit 3 enable, bit 7 saved copy.
        reg_op(1, 32'hFFFF_FFFF, 0, 0, "R12", 32'h88);
        reg_op(1, 32'h0000_0008, 0, 0, "R12", 32'h08);
        reg_op(0, '0, 1, 0, "R9", 32'h80);
        reg_op(0, '0, 1, 0, "R9", 32'h00);
        reg_op(1, 32'h0000_0080, 0, 0, "R12", 32'h80);
        reg_op(0, '0, 0, 1, "R10", 32'h88);
        reg_op(1, 32'h0000_0008, 0, 0, "R12", 32'h08);
        reg_op(0, '0, 0, 1, "R10", 32'h00);
        reg_op(1, 32'h0000_0008, 0, 0, "R12", 32'h08);
        reg_op(0, '0, 1, 1, "R11", 32'h80);
        reg_op(1, 32'h0000_0088, 0, 0, "R12", 32'h88);
        reg_op(1, 32'h0000_0000, 1, 1, "R11", 32'h80);
        reg_op(1, 32'h0000_0008, 0, 1, "R11", 32'h88);

        // Gate sweep for both enable-bit values.
        for (int m = 0; m < 2; m++) begin
            reg_op(1, (m != 0) ? 32'h8 : 32'h0, 0, 0, "R12", (m != 0) ? 32'h8 : 32'h0);
            for (int p = 0; p < 3; p++) begin
                for (int b = 0; b < 64; b++) begin
                    for (int q = 0; q < 8; q++) begin
                        logic [1:0] pv;
                        logic mo, co, hi, ps, pn, e0s, e0n, e1;
                        string tag_s, tag_n, tag1;
                        pv = (p == 2) ? 2'b11 : 2'(p);
                        mo = q[0]; co = q[1]; hi = q[2];
                        @(negedge clk);
                        priv = pv; virt = b[0]; mie = b[1]; sie = b[2]; vsie = b[3]; md = b[4]; hd = b[5];
                        act = {4'(1 + (b % 3)), 4'd0};
                        mode_ok = {NTRIG{mo}}; ctx_ok = {NTRIG{co}}; hit = {NTRIG{hi}};
                        #1;
                        ps  = permit_s(pv, b[0], b[1], b[2], b[3], b[4], b[5]);
                        pn  = !(pv == 2'b11 && m == 0);
                        e0s = mo && co && ps;
                        e0n = mo && co && pn;
                        e1  = mo && co;
                        if (!(mo && co)) begin
                            tag_s = "R3"; tag_n = "R3"; tag1 = "R3";
                        end else begin
                            tag1  = "R2";
                            tag_n = "R8";
                            tag_s = (pv == 2'b11) ? "R4" : (pv == 2'b00) ? "R6" : b[0] ? "R6" : "R5";
                        end
                        chk(tag_s, 32'(qual_s[0]), 32'(e0s));
                        chk(tag_n, 32'(qual_n[0]), 32'(e0n));
                        chk(tag1, 32'(qual_s[1]), 32'(e1));
                        chk(tag1, 32'(qual_n[1]), 32'(e1));
                        chk("R13", 32'(fire_s), 32'({e1 && hi, e0s && hi}));
                        chk("R13", 32'(fire_n), 32'({e1 && hi, e0n && hi}));
                    end
                end
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule